// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is a bank of 32 general-purpose lines behind a single-cycle, word-wide register port. Software sets each line's direction, open-drain mode and output value. It reads back the line states and configures which input lines report edges. Each line has two enable bits: one sets whether its input is seen at all, and a sense bit picks falling-only or both-edge capture. Captured edges are held in an event register that software clears by writing ones. A single interrupt output is raised whenever an unmasked event is pending.

Register bits use reversed numbering. Line n is held in register bit 31−n, so line 0 is the MSB. The pin vectors at the ports are indexed by line number. Each input passes through a two-flop synchroniser, and edges are found by comparing the synchronised value with its value one cycle earlier. A write takes effect at the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and every `pin_oe` bit is 0.
- R2: The direction (0x00), open-drain (0x04), mask (0x10), sense (0x14) and input-enable (0x18) registers read back exactly the word last written.
- R3: Line n is held in register bit 31−n. `pin_oe[n]` is 1 only when line n is an output (direction bit 1), and `pin_out[n]` follows data bit 31−n.
- R4: When a line is an output in open-drain mode, `pin_oe` for that line is 1 while its data bit is 0 and 0 while its data bit is 1.
- R5: Reading data (0x08) returns the stored value for output lines, the synchronised pin for input lines whose input-enable bit is 1, and 0 for input lines whose input-enable bit is 0.
- R6: With sense bit 1 a line captures only falling edges. With sense bit 0 it captures both rising and falling edges.
- R7: An edge sets its event bit (0x0C) only when the line is an input with its input-enable bit set.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: When an edge and a clearing write hit the same event bit on the same clock edge, the bit ends up set.
- R10: `irq` is 1 exactly when the event and mask registers share a set bit.
- R11: A pin change made between clock edges shows up in the event register after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin inputs, indexed by line |
| pin_out | output | 32 | Output values, indexed by line |
| pin_oe | output | 32 | Output enables, indexed by line |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an edge-driven set of an event bit landing on the same clock edge as a write that clears that bit. The synchroniser delay hides the exact set cycle. The stimulus counts edges from the pin change: the pin changes on a falling clock edge, two rising edges pass, and the clearing write is then issued so that it commits on the third rising edge. The same counting is used to check that the event is still absent one edge earlier.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
    localparam int unsigned OFS_W = 5;
    localparam logic [OFS_W-1:0] OFS_DIR   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_ODRN  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_DATA  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_EVT   = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_SENSE = 5'h14;
    localparam logic [OFS_W-1:0] OFS_INEN  = 5'h18;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_event_cap.sv
module pin_event_cap #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] gate,
    input  logic [W-1:0] fall_only,
    input  logic [W-1:0] clr,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;
    logic [W-1:0] evt_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] set_vec;

    always_comb begin
        rise    = smp & ~prev_q;
        fall    = ~smp & prev_q;
        set_vec = (fall | (rise & ~fall_only)) & gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            evt_q  <= '0;
        end else begin
            prev_q <= smp;
            evt_q  <= (evt_q & ~clr) | set_vec;
        end
    end

    assign evt = evt_q;

    // R9: a detected edge always leaves its bit set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

    // R7: new event bits only where the line was gated in
    a_r7_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(gate)) == '0));

    // R8: a clearing write without a competing edge empties the bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & $past(clr) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pin_bank_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq
);
    localparam int unsigned MSB = NLINES - 1;

    logic [NLINES-1:0] dir_q, odrn_q, data_q, mask_q, sense_q, inen_q;
    logic [NLINES-1:0] in_bits, in_sync, evt, evt_clr, data_rd;

    // line n <-> register bit MSB-n
    for (genvar n = 0; n < NLINES; n++) begin : g_line
        assign in_bits[MSB-n] = pin_in[n];
        assign pin_out[n]     = data_q[MSB-n];
        assign pin_oe[n]      = dir_q[MSB-n] & ~(odrn_q[MSB-n] & data_q[MSB-n]);
    end

    pin_sync #(.W(NLINES), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_bits),
        .q     (in_sync)
    );

    assign evt_clr = (bus_we && bus_addr == OFS_EVT) ? bus_wdata : '0;

    pin_event_cap #(.W(NLINES)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (in_sync),
        .gate      (~dir_q & inen_q),
        .fall_only (sense_q),
        .clr       (evt_clr),
        .evt       (evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            odrn_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
            sense_q <= '0;
            inen_q  <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_DIR:   dir_q   <= bus_wdata;
                OFS_ODRN:  odrn_q  <= bus_wdata;
                OFS_DATA:  data_q  <= bus_wdata;
                OFS_MASK:  mask_q  <= bus_wdata;
                OFS_SENSE: sense_q <= bus_wdata;
                OFS_INEN:  inen_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign data_rd = (dir_q & data_q) | (~dir_q & inen_q & in_sync);

    always_comb begin
        unique case (bus_addr)
            OFS_DIR:   bus_rdata = dir_q;
            OFS_ODRN:  bus_rdata = odrn_q;
            OFS_DATA:  bus_rdata = data_rd;
            OFS_EVT:   bus_rdata = evt;
            OFS_MASK:  bus_rdata = mask_q;
            OFS_SENSE: bus_rdata = sense_q;
            OFS_INEN:  bus_rdata = inen_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(evt & mask_q);

    // R10: interrupt needs at least one enabled mask bit
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    // R3: input lines are never driven
    a_r3_no_drive_in: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~{<<{dir_q}}) == '0);
endmodule

// File: tb/pin_bank_ctrl_bench.sv
module pin_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pin_bank_ctrl u_pin_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
        A_EVT = 5'h0C, A_MSK = 5'h10, A_SNS = 5'h14, A_INE = 5'h18;

    localparam int NV = 5;
    localparam logic [4:0]  V_ADDR [NV] = '{A_DIR, A_ODR, A_MSK, A_SNS, A_INE};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0F0F, 32'h1234_5678,
        32'hFFFF_0000, 32'h8000_0001, 32'hDEAD_BEEF};

    function automatic logic [31:0] lb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called just after a falling edge; commits on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        for (int a = 0; a <= 24; a += 4) begin
            rd(5'(a), r); chk("R1 reg", r, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 oe", pin_oe, 32'h0);

        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_DATA[i]);
            rd(V_ADDR[i], r);
            chk("R2 readback", r, V_DATA[i]);
        end
        for (int i = 0; i < NV; i++) wr(V_ADDR[i], 32'h0);

        // R3/R4 output mapping and open drain
        wr(A_DIR, lb(0) | lb(5));
        wr(A_ODR, lb(5));
        wr(A_DAT, lb(0) | lb(5));
        chk("R3 oe", pin_oe, 32'h0000_0001);
        chk("R3 out", pin_out & 32'h21, 32'h0000_0021);
        chk("R4 od released", {31'h0, pin_oe[5]}, 32'h0);
        wr(A_DAT, lb(0));
        chk("R4 od driven", pin_oe, 32'h0000_0021);

        // R5 data read mix
        wr(A_INE, lb(7));
        pin_in = 32'hFFFF_FFFF;
        wait_n(4);
        rd(A_DAT, r); chk("R5 data mix", r, lb(0) | lb(7));

        // event setup
        wr(A_DIR, 32'h0);
        wr(A_INE, 32'hFFFF_FFFF);
        wr(A_SNS, lb(2));
        wait_n(4);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, r); chk("R8 clear all", r, 32'h0);

        // R11 latency
        pin_in[3] = 1'b0;
        wait_n(2);
        rd(A_EVT, r); chk("R11 not yet", r, 32'h0);
        wait_n(1);
        rd(A_EVT, r); chk("R11 arrived", r, lb(3));
        wr(A_EVT, lb(3));

        // R6 sense
        pin_in[2] = 1'b0; wait_n(4);
        rd(A_EVT, r); chk("R6 fall captured", r, lb(2));
        wr(A_EVT, lb(2));
        pin_in[2] = 1'b1; wait_n(4);
        rd(A_EVT, r); chk("R6 rise ignored", r, 32'h0);
        pin_in[3] = 1'b1; wait_n(4);
        rd(A_EVT, r); chk("R6 both-edge rise", r, lb(3));
        wr(A_EVT, 32'hFFFF_FFFF);

        // R7 gating
        wr(A_DIR, lb(9));
        wr(A_INE, ~lb(10));
        pin_in[9] = 1'b0; pin_in[10] = 1'b0; wait_n(4);
        rd(A_EVT, r); chk("R7 gated off", r, 32'h0);
        wr(A_DIR, 32'h0);
        wr(A_INE, 32'hFFFF_FFFF);

        // R10 irq
        pin_in[4] = 1'b0; pin_in[6] = 1'b0; wait_n(4);
        chk("R10 masked", {31'h0, irq}, 32'h0);
        wr(A_MSK, lb(4));
        chk("R10 enabled", {31'h0, irq}, 32'h1);
        wr(A_MSK, lb(5));
        chk("R10 other bit", {31'h0, irq}, 32'h0);

        // R8 selective clear
        wr(A_EVT, lb(4));
        rd(A_EVT, r); chk("R8 one cleared", r, lb(6));
        wr(A_EVT, 32'h0);
        rd(A_EVT, r); chk("R8 zero keeps", r, lb(6));
        wr(A_EVT, 32'hFFFF_FFFF);

        // R9 set and clear on the same edge
        pin_in[12] = 1'b0;
        wait_n(2);
        wr(A_EVT, lb(12));
        rd(A_EVT, r); chk("R9 set wins", r, lb(12));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule